// File: doc/BRIEF.md
# Video Clamp Request Controller

This block produces the once-per-line clamp request for a three-channel video digitiser. The request window is taken either from an internal line timer or from an external clamp pin, chosen by a configuration bit. The timer runs in the pixel clock domain and is started by the rising edge of the recovered horizontal reference. The external pin and the vertical sync input are asynchronous, and each passes through a two-flop synchroniser before use. The clamp itself starts when the request falls. While the request is high, a blanking output tells the converters to emit blanking codes.

When inhibiting is enabled, the request is held at 0 while vertical sync is active. The block switches into and out of inhibit only while the source request is low. A vertical sync that arrives while the request is high therefore never cuts the pulse short and never creates a false falling edge that would start a clamp. The block also drives a coast output for the PLL from the synchronised vertical sync. It raises a one-cycle error flag when a vertical sync edge and a horizontal reference edge fall in the same cycle while coasting is enabled. It holds three signed 9-bit black-level offsets, one per colour channel, and clips each written value to the legal range.

Top module: `clamp_req_ctrl`

The internal timer is a state machine with the states T_IDLE, T_WAIT and T_PULSE. It has these transitions:
- T_IDLE to T_WAIT on a reference rise when the delay is not 0.
- T_IDLE to T_PULSE on a reference rise when the delay is 0.
- T_WAIT to T_PULSE when the delay count runs out.
- T_PULSE to T_IDLE when the width count runs out.

A zero width keeps the timer in T_IDLE.

The inhibit state machine has the states I_PASS and I_INHIBIT. It has these transitions:
- I_PASS to I_INHIBIT when inhibit is wanted and the source request is low.
- I_INHIBIT to I_PASS when inhibit is no longer wanted and the source request is low.

## Requirements
- R1: With `src_ext`=0, a rising edge of `hsync_ref` sampled at clock edge E0 makes `clamp_req` high after edge E0+`clamp_start`, for exactly `clamp_width` cycles.
- R2: A write stores the value clipped to the range -24..+136 in the channel chosen by `ofs_sel` (0, 1 or 2). The values are 9-bit two's complement.
- R3: With `src_ext`=1, `clamp_req` follows `ext_clamp` two clock edges later.
- R4: A `hsync_ref` rise while the timer is waiting or pulsing is ignored. A `clamp_width` of 0 gives no pulse.
- R5: `blank` is high exactly while `clamp_req` is high.
- R6: With `inhibit_en`=1 and the synchronised `vsync` high, a request that rises is held at 0. With `inhibit_en`=0, `vsync` has no effect on `clamp_req`.
- R7: Inhibit takes effect and is released only while the source request is low. A `vsync` during a high request does not end that request. A `vsync` that falls while the source is high keeps the output at 0 until the source goes low.
- R8: `coast` equals the `vsync` input, delayed by two clock edges, when `coast_en`=1, and is 0 when `coast_en`=0.
- R9: With `coast_en`=1, `coast_err` pulses high for one cycle when an edge of the synchronised `vsync` and an edge of `hsync_ref` occur in the same cycle. It stays 0 when the edges fall in different cycles or when `coast_en`=0.
- R10: After reset, `clamp_req`, `blank`, `coast` and `coast_err` are 0, and all three offsets are 0.
- R11: A write with `ofs_sel`=3 changes no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ext | input | 1 | 1 selects the external clamp pin, 0 selects the internal timer |
| inhibit_en | input | 1 | Enables suppression of the request by vertical sync |
| coast_en | input | 1 | Vertical sync is used to coast the PLL |
| clamp_start | input | 8 | Delay from the reference rise to the start of the window, in clocks |
| clamp_width | input | 8 | Length of the internal window, in clocks |
| hsync_ref | input | 1 | Recovered horizontal reference, synchronous to clk |
| ext_clamp | input | 1 | External clamp pin, asynchronous |
| vsync | input | 1 | Vertical sync, asynchronous |
| ofs_we | input | 1 | Offset write strobe |
| ofs_sel | input | 2 | Offset channel select |
| ofs_wdata | input | 9 | Signed offset write value |
| clamp_req | output | 1 | Clamp request; the clamp starts on its falling edge |
| blank | output | 1 | Forces the converter outputs to blanking |
| coast | output | 1 | PLL coast request |
| coast_err | output | 1 | Coincident vertical and horizontal edges seen |
| ofs_ch0 | output | 9 | Black-level offset, channel 0 |
| ofs_ch1 | output | 9 | Black-level offset, channel 1 |
| ofs_ch2 | output | 9 | Black-level offset, channel 2 |

## Verification
The internal timer is run with a nonzero delay, a zero delay and a zero width. Comparing these separates an off-by-one in either count from a missing special case. A second reference rise inside a pending window shows whether the timer restarts when it should ignore the rise. Vertical sync is applied while the request is low and again while it is high, then released in each of those conditions. This separates immediate gating, which would cut the pulse or cause an early rise, from the deferred switching that is required. The coast error is driven with vertical and horizontal edges in the same cycle and one cycle apart, and once with coasting off. The offsets are written at each limit and one step beyond it, with extreme values and with the unused select code.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
    localparam int NUM_CH = 3;
    localparam int SEL_W  = 2;
    localparam int OFS_W  = 9;
    localparam int CNT_W  = 8;

    localparam logic signed [OFS_W-1:0] OFS_LO = -9'sd24;
    localparam logic signed [OFS_W-1:0] OFS_HI = 9'sd136;

    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_WAIT  = 2'd1,
        T_PULSE = 2'd2
    } tmr_state_t;

    typedef enum logic {
        I_PASS    = 1'b0,
        I_INHIBIT = 1'b1
    } inh_state_t;

    function automatic logic signed [OFS_W-1:0] clip_ofs(input logic signed [OFS_W-1:0] v);
        if (v < OFS_LO)      return OFS_LO;
        else if (v > OFS_HI) return OFS_HI;
        else                 return v;
    endfunction
endpackage

// File: rtl/clamp_sync2.sv
module clamp_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/clamp_line_timer.sv
module clamp_line_timer
    import clamp_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hsync_ref,
    input  logic [W-1:0] start_dly,
    input  logic [W-1:0] width,
    output logic         pulse
);
    tmr_state_t   state, state_nx;
    logic [W-1:0] cnt, cnt_nx;
    logic         hs_d;
    logic         hs_rise;

    assign hs_rise = hsync_ref & ~hs_d;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            T_IDLE: begin
                if (hs_rise && width != '0) begin
                    if (start_dly == '0) begin
                        state_nx = T_PULSE;
                        cnt_nx   = width - 1'b1;
                    end else begin
                        state_nx = T_WAIT;
                        cnt_nx   = start_dly - 1'b1;
                    end
                end
            end
            T_WAIT: begin
                if (cnt == '0) begin
                    state_nx = T_PULSE;
                    cnt_nx   = width - 1'b1;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            T_PULSE: begin
                if (cnt == '0) begin
                    state_nx = T_IDLE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: begin
                state_nx = T_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            cnt   <= '0;
            hs_d  <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            hs_d  <= hsync_ref;
        end
    end

    always_comb begin
        pulse = (state == T_PULSE);
    end
endmodule

// File: rtl/clamp_inhibit_fsm.sv
module clamp_inhibit_fsm
    import clamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_req,
    input  logic       inhibit_en,
    input  logic       vs_sync,
    output inh_state_t state,
    output logic       clamp_req,
    output logic       blank
);
    inh_state_t state_nx;
    logic       want_inh;

    assign want_inh = inhibit_en & vs_sync;

    always_comb begin
        state_nx = state;
        unique case (state)
            I_PASS:    if (want_inh && !raw_req)  state_nx = I_INHIBIT;
            I_INHIBIT: if (!want_inh && !raw_req) state_nx = I_PASS;
            default:   state_nx = I_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= I_PASS;
        else        state <= state_nx;
    end

    always_comb begin
        clamp_req = (state == I_PASS) && raw_req;
        blank     = clamp_req;
    end
endmodule

// File: rtl/clamp_coast_mon.sv
module clamp_coast_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic coast_en,
    input  logic vs_sync,
    input  logic hsync_ref,
    output logic coast,
    output logic coast_err
);
    logic vs_d, hs_d;
    logic vs_edge, hs_edge;

    assign vs_edge = vs_sync ^ vs_d;
    assign hs_edge = hsync_ref ^ hs_d;
    assign coast   = coast_en & vs_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_d      <= 1'b0;
            hs_d      <= 1'b0;
            coast_err <= 1'b0;
        end else begin
            vs_d      <= vs_sync;
            hs_d      <= hsync_ref;
            coast_err <= coast_en & vs_edge & hs_edge;
        end
    end
endmodule

// File: rtl/clamp_offset_bank.sv
module clamp_offset_bank
    import clamp_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [SEL_W-1:0]                    wr_sel,
    input  logic signed [OFS_W-1:0]             wr_data,
    output logic [NUM_CH-1:0][OFS_W-1:0]        ofs
);
    logic signed [OFS_W-1:0] clipped;

    assign clipped = clip_ofs(wr_data);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ofs[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                ofs[g] <= clipped;
        end
    end
endmodule

// File: rtl/clamp_req_ctrl.sv
module clamp_req_ctrl
    import clamp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    src_ext,
    input  logic                    inhibit_en,
    input  logic                    coast_en,
    input  logic [CNT_W-1:0]        clamp_start,
    input  logic [CNT_W-1:0]        clamp_width,
    input  logic                    hsync_ref,
    input  logic                    ext_clamp,
    input  logic                    vsync,
    input  logic                    ofs_we,
    input  logic [SEL_W-1:0]        ofs_sel,
    input  logic signed [OFS_W-1:0] ofs_wdata,
    output logic                    clamp_req,
    output logic                    blank,
    output logic                    coast,
    output logic                    coast_err,
    output logic signed [OFS_W-1:0] ofs_ch0,
    output logic signed [OFS_W-1:0] ofs_ch1,
    output logic signed [OFS_W-1:0] ofs_ch2
);
    logic [1:0]                   sync_q;
    logic                         ext_sync, vs_sync;
    logic                         int_pulse, raw_req;
    inh_state_t                   inh_state;
    logic [NUM_CH-1:0][OFS_W-1:0] ofs;

    clamp_sync2 #(.WIDTH(2)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({vsync, ext_clamp}),
        .q_sync(sync_q)
    );
    assign ext_sync = sync_q[0];
    assign vs_sync  = sync_q[1];

    clamp_line_timer #(.W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .hsync_ref(hsync_ref),
        .start_dly(clamp_start),
        .width(clamp_width),
        .pulse(int_pulse)
    );

    assign raw_req = src_ext ? ext_sync : int_pulse;

    clamp_inhibit_fsm i_inh (
        .clk(clk), .rst_n(rst_n),
        .raw_req(raw_req),
        .inhibit_en(inhibit_en),
        .vs_sync(vs_sync),
        .state(inh_state),
        .clamp_req(clamp_req),
        .blank(blank)
    );

    clamp_coast_mon i_coast (
        .clk(clk), .rst_n(rst_n),
        .coast_en(coast_en),
        .vs_sync(vs_sync),
        .hsync_ref(hsync_ref),
        .coast(coast),
        .coast_err(coast_err)
    );

    clamp_offset_bank i_ofs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ofs_we),
        .wr_sel(ofs_sel),
        .wr_data(ofs_wdata),
        .ofs(ofs)
    );

    assign ofs_ch0 = ofs[0];
    assign ofs_ch1 = ofs[1];
    assign ofs_ch2 = ofs[2];
endmodule

// File: rtl/clamp_req_ctrl_chk.sv
module clamp_req_ctrl_chk
    import clamp_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    inhibit_en,
    input logic                    coast_en,
    input logic                    vs_sync,
    input logic                    raw_req,
    input inh_state_t              inh_state,
    input logic                    clamp_req,
    input logic                    coast_err,
    input logic signed [OFS_W-1:0] ofs_ch0,
    input logic signed [OFS_W-1:0] ofs_ch1,
    input logic signed [OFS_W-1:0] ofs_ch2
);
    // R2: stored offsets never leave the legal range
    a_r2_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_ch0 >= OFS_LO) && (ofs_ch0 <= OFS_HI) &&
        (ofs_ch1 >= OFS_LO) && (ofs_ch1 <= OFS_HI) &&
        (ofs_ch2 >= OFS_LO) && (ofs_ch2 <= OFS_HI));

    // R7: the inhibit state changes only while the source request is low
    a_r7_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_state != $past(inh_state)) |-> !$past(raw_req));

    // R6: steady inhibit with a low request keeps the request low
    a_r6_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_en && $past(inhibit_en) && vs_sync && $past(vs_sync) && !$past(clamp_req))
        |-> !clamp_req);

    // R9: an error pulse needs coasting enabled one cycle earlier
    a_r9_err_needs_coast: assert property (@(posedge clk) disable iff (!rst_n)
        coast_err |-> $past(coast_en));
endmodule

bind clamp_req_ctrl clamp_req_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n),
    .inhibit_en(inhibit_en), .coast_en(coast_en),
    .vs_sync(vs_sync), .raw_req(raw_req), .inh_state(inh_state),
    .clamp_req(clamp_req), .coast_err(coast_err),
    .ofs_ch0(ofs_ch0), .ofs_ch1(ofs_ch1), .ofs_ch2(ofs_ch2)
);

// File: tb/test_clamp_req_ctrl.sv
module test_clamp_req_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_ext = 1'b0, inhibit_en = 1'b0, coast_en = 1'b0;
    logic [7:0] clamp_start = 8'd0, clamp_width = 8'd0;
    logic       hsync_ref = 1'b0, ext_clamp = 1'b0, vsync = 1'b0;
    logic       ofs_we = 1'b0;
    logic [1:0] ofs_sel = 2'd0;
    logic [8:0] ofs_wdata = 9'd0;
    logic       clamp_req, blank, coast, coast_err;
    logic [8:0] ofs_ch0, ofs_ch1, ofs_ch2;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    clamp_req_ctrl i_clamp_req_ctrl (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .inhibit_en(inhibit_en),
        .coast_en(coast_en), .clamp_start(clamp_start), .clamp_width(clamp_width),
        .hsync_ref(hsync_ref), .ext_clamp(ext_clamp), .vsync(vsync),
        .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_wdata(ofs_wdata),
        .clamp_req(clamp_req), .blank(blank), .coast(coast), .coast_err(coast_err),
        .ofs_ch0(ofs_ch0), .ofs_ch1(ofs_ch1), .ofs_ch2(ofs_ch2)
    );

    // {sel, write value, expected stored value}, 9-bit two's complement
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 9'h064, 9'h064},
        {2'd1, 9'h088, 9'h088},
        {2'd1, 9'h089, 9'h088},
        {2'd2, 9'h1E8, 9'h1E8},
        {2'd2, 9'h1E7, 9'h1E8},
        {2'd0, 9'h0FF, 9'h088},
        {2'd1, 9'h100, 9'h1E8},
        {2'd2, 9'h032, 9'h032},
        {2'd0, 9'h1F6, 9'h1F6},
        {2'd0, 9'h000, 9'h000}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int ofs_of(input logic [1:0] s);
        case (s)
            2'd0:    return int'(ofs_ch0);
            2'd1:    return int'(ofs_ch1);
            default: return int'(ofs_ch2);
        endcase
    endfunction

    task automatic run_timer(input int st, input int wd, input string tag);
        clamp_start = 8'(st);
        clamp_width = 8'(wd);
        hsync_ref = 1'b0;
        wait_n(2);
        hsync_ref = 1'b1;
        for (int k = 0; k < st + wd + 4; k++) begin
            @(negedge clk);
            chk(tag, int'(clamp_req), int'(k >= st && k < st + wd));
            chk("R5", int'(blank), int'(k >= st && k < st + wd));
        end
        hsync_ref = 1'b0;
        wait_n(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        // R10: reset state
        chk("R10", int'(clamp_req), 0);
        chk("R10", int'(blank), 0);
        chk("R10", int'(coast), 0);
        chk("R10", int'(coast_err), 0);
        chk("R10", int'(ofs_ch0) + int'(ofs_ch1) + int'(ofs_ch2), 0);
        rst_n = 1'b1;
        wait_n(2);

        // R2: offset write vectors
        for (int v = 0; v < NV; v++) begin
            ofs_we = 1'b1;
            ofs_sel = VEC[v][19:18];
            ofs_wdata = VEC[v][17:9];
            @(negedge clk);
            ofs_we = 1'b0;
            chk("R2", ofs_of(VEC[v][19:18]), int'(VEC[v][8:0]));
        end

        // R11: select 3 writes nothing
        ofs_we = 1'b1; ofs_sel = 2'd3; ofs_wdata = 9'h077;
        @(negedge clk);
        ofs_we = 1'b0;
        chk("R11", int'(ofs_ch0), 0);
        chk("R11", int'(ofs_ch1), int'(9'h1E8));
        chk("R11", int'(ofs_ch2), int'(9'h032));

        // R1: internal timer windows
        run_timer(3, 4, "R1");
        run_timer(0, 2, "R1");
        run_timer(5, 1, "R1");
        // R4: zero width gives nothing
        run_timer(2, 0, "R4");

        // R4: second rise inside the pending window is ignored
        clamp_start = 8'd2; clamp_width = 8'd3;
        hsync_ref = 1'b1;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            chk("R4", int'(clamp_req), int'(k >= 2 && k <= 4));
            if (k == 0) hsync_ref = 1'b0;
            if (k == 2) hsync_ref = 1'b1;
        end
        hsync_ref = 1'b0;
        clamp_width = 8'd0;
        wait_n(3);

        // R3: external source, two-edge latency
        src_ext = 1'b1;
        ext_clamp = 1'b1;
        @(negedge clk); chk("R3", int'(clamp_req), 0);
        @(negedge clk); chk("R3", int'(clamp_req), 1);
        chk("R5", int'(blank), 1);
        ext_clamp = 1'b0;
        @(negedge clk); chk("R3", int'(clamp_req), 1);
        @(negedge clk); chk("R3", int'(clamp_req), 0);
        wait_n(2);

        // R6: inhibit_en=0, vsync has no effect
        vsync = 1'b1;
        wait_n(4);
        ext_clamp = 1'b1;
        wait_n(3);
        chk("R6", int'(clamp_req), 1);
        ext_clamp = 1'b0; vsync = 1'b0;
        wait_n(4);

        // R6: inhibit engaged while low suppresses the request
        inhibit_en = 1'b1;
        vsync = 1'b1;
        wait_n(4);
        ext_clamp = 1'b1;
        wait_n(4);
        chk("R6", int'(clamp_req), 0);
        chk("R5", int'(blank), 0);
        // R7: release deferred while source still high
        vsync = 1'b0;
        wait_n(4);
        chk("R7", int'(clamp_req), 0);
        ext_clamp = 1'b0;
        wait_n(4);
        ext_clamp = 1'b1;
        wait_n(3);
        chk("R7", int'(clamp_req), 1);
        // R7: vsync during a high request does not cut it
        vsync = 1'b1;
        wait_n(5);
        chk("R7", int'(clamp_req), 1);
        ext_clamp = 1'b0;
        wait_n(3);
        chk("R7", int'(clamp_req), 0);
        ext_clamp = 1'b1;
        wait_n(4);
        chk("R6", int'(clamp_req), 0);
        ext_clamp = 1'b0; vsync = 1'b0;
        wait_n(6);
        inhibit_en = 1'b0;
        src_ext = 1'b0;

        // R8: coast output
        vsync = 1'b1;
        wait_n(3);
        chk("R8", int'(coast), 0);
        coast_en = 1'b1;
        @(negedge clk);
        chk("R8", int'(coast), 1);
        vsync = 1'b0;
        @(negedge clk); chk("R8", int'(coast), 1);
        @(negedge clk); chk("R8", int'(coast), 0);
        wait_n(2);

        // R9: coincident edges flag an error
        vsync = 1'b1;
        wait_n(2);
        hsync_ref = 1'b1;
        @(negedge clk); chk("R9", int'(coast_err), 1);
        @(negedge clk); chk("R9", int'(coast_err), 0);
        // R9: edges one cycle apart do not
        vsync = 1'b0;
        wait_n(3);
        hsync_ref = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9", int'(coast_err), 0);
        end
        // R9: coincident edges with coasting off
        coast_en = 1'b0;
        vsync = 1'b1;
        wait_n(2);
        hsync_ref = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9", int'(coast_err), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule